// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a chipset watchdog that software controls through a small byte-addressed register bus with 16-bit data. A prescaler divides the system clock into coarse ticks. Each tick lowers a 10-bit countdown by one. When a tick arrives while the count is already zero, that tick is an expiry, and the count reloads from the initial-value register.

The first expiry only records a timeout flag. An expiry that arrives while that flag is still set is a second-stage timeout. It records a second status flag and, unless the external lock input is high, emits a one-cycle reboot request and latches a boot flag. Software keeps the system alive in two ways. It can write the reload code, or it can clear the first-stage flag, which brings back the need for two full countdowns before a reboot. A halt bit in the control register freezes the countdown.

Reads are combinational from the address. Writes take effect at the clock edge where the write enable is high. The tick length is set by the `TICK_DIV` parameter in clock cycles. The value that the count and the initial-value register take at reset is set by `INIT_DEFAULT`.

Top module: `two_stage_wdt`

## Requirements
- R1: After reset the halt bit reads 1, every status bit reads 0, and both the initial-value register and the count equal `INIT_DEFAULT`.
- R2: The initial-value register at offset 0x12 stores bits 9:0 of a write. Its bits 15:10 always read 0, and written data cannot change them.
- R3: A write of 0, 1, 2 or 3 to the initial-value register is ignored, and read-back still shows the previous value.
- R4: A write of exactly 0x0001 to offset 0x00 loads the count from the initial-value register and restarts the prescaler. Any other value written there has no effect.
- R5: A read of offset 0x00 returns the current count in bits 9:0, with 0 in the upper bits.
- R6: Control bit 11 at offset 0x08 is the halt bit and reads back as written. While it is 1, neither the count nor the prescaler moves.
- R7: While running, the count drops by one every `TICK_DIV` cycles. A tick at count 0 is an expiry and reloads the count. The first expiry therefore lands (initial value + 1) x `TICK_DIV` cycles after the halt bit is cleared or after a reload.
- R8: An expiry while status-1 bit 3 (offset 0x04) is clear sets that bit and does nothing else.
- R9: An expiry while status-1 bit 3 is set does three things: it sets status-2 bit 1 (offset 0x06), raises the reboot request, and sets status-2 bit 2, the boot flag.
- R10: A status bit clears when 1 is written to its position, and writing 0 leaves it unchanged. Clearing status-1 bit 3 means the next expiry is again a first-stage one. If an expiry and a clearing write fall in the same cycle, the expiry wins.
- R11: While the lock input is high, a second-stage expiry still sets status-2 bit 1, but it raises no reboot request and does not set the boot flag.
- R12: The reboot request is high for exactly one clock cycle for each second-stage expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| rebootLock | input | 1 | High blocks the reboot request |
| rebootReq | output | 1 | One-cycle reboot request pulse |

## Verification
The bench builds the block with `TICK_DIV` = 4 and `INIT_DEFAULT` = 20. After the bench writes an initial value of 6, one countdown takes 28 cycles. At that scale the bench can reach first-stage and second-stage expiries, the service write that clears the first-stage flag, and the locked second-stage case in a few hundred cycles. It predicts the exact cycle of each expiry from the edge at which the halt bit was cleared.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 10;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STS1   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STS2   = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

  localparam int HALT_BIT   = 11;
  localparam int FIRST_BIT  = 3;
  localparam int SECOND_BIT = 1;
  localparam int BOOT_BIT   = 2;
  localparam int MIN_INIT   = 4;

  localparam logic [REG_W-1:0] RELOAD_CODE = 16'h0001;

  // strobes and settings from the register file to the countdown path
  typedef struct packed {
    logic             reload;
    logic             halt;
    logic [CNT_W-1:0] initVal;
  } core_ctl_t;
endpackage

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int TICK_DIV     = 20_000_000,
  parameter int INIT_DEFAULT = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  core_ctl_t        ctl,
  output logic [CNT_W-1:0] cnt,
  output logic             expiry
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic             tick;

  assign tick   = !ctl.halt && (preCnt == PRE_LAST);
  assign expiry = !ctl.reload && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= CNT_W'(INIT_DEFAULT);
    end else if (ctl.reload) begin
      preCnt <= '0;
      cnt    <= ctl.initVal;
    end else if (ctl.halt) begin
      preCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      cnt    <= (cnt == '0) ? ctl.initVal : cnt - 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.halt && !ctl.reload) |=> $stable(cnt)); // R6

  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.reload |=> (cnt == $past(ctl.initVal))); // R4
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int INIT_DEFAULT = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              rebootLock,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              expiry,
  output core_ctl_t         ctl,
  output logic              rebootReq
);
  logic [CNT_W-1:0] initReg;
  logic             haltReg;
  logic             firstTo;
  logic             secondTo;
  logic             bootSts;
  logic             wrInit, wrCtrl, wrSts1, wrSts2;
  logic             fire;

  assign wrInit = wrEn && (addr == OFS_INIT);
  assign wrCtrl = wrEn && (addr == OFS_CTRL);
  assign wrSts1 = wrEn && (addr == OFS_STS1);
  assign wrSts2 = wrEn && (addr == OFS_STS2);
  assign fire   = expiry && firstTo && !rebootLock;

  assign ctl.reload  = wrEn && (addr == OFS_RELOAD) && (wrData == RELOAD_CODE);
  assign ctl.halt    = haltReg;
  assign ctl.initVal = initReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initReg   <= CNT_W'(INIT_DEFAULT);
      haltReg   <= 1'b1;
      firstTo   <= 1'b0;
      secondTo  <= 1'b0;
      bootSts   <= 1'b0;
      rebootReq <= 1'b0;
    end else begin
      if (wrInit && (wrData[CNT_W-1:0] >= CNT_W'(MIN_INIT)))
        initReg <= wrData[CNT_W-1:0];
      if (wrCtrl)
        haltReg <= wrData[HALT_BIT];
      if (expiry)
        firstTo <= 1'b1;
      else if (wrSts1 && wrData[FIRST_BIT])
        firstTo <= 1'b0;
      if (expiry && firstTo)
        secondTo <= 1'b1;
      else if (wrSts2 && wrData[SECOND_BIT])
        secondTo <= 1'b0;
      if (fire)
        bootSts <= 1'b1;
      else if (wrSts2 && wrData[BOOT_BIT])
        bootSts <= 1'b0;
      rebootReq <= fire;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      OFS_RELOAD: rdData[CNT_W-1:0] = cnt;
      OFS_STS1:   rdData[FIRST_BIT] = firstTo;
      OFS_STS2: begin
        rdData[SECOND_BIT] = secondTo;
        rdData[BOOT_BIT]   = bootSts;
      end
      OFS_CTRL:   rdData[HALT_BIT]  = haltReg;
      OFS_INIT:   rdData[CNT_W-1:0] = initReg;
      default:    rdData = '0;
    endcase
  end

  AST_REBOOT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rebootReq |=> !rebootReq); // R12

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    rebootLock |=> !rebootReq); // R11

  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secondTo) |-> $past(firstTo)); // R9

  AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    initReg >= CNT_W'(MIN_INIT)); // R3
endmodule

// File: rtl/two_stage_wdt.sv
module two_stage_wdt
  import wdt_pkg::*;
#(
  parameter int TICK_DIV     = 20_000_000,
  parameter int INIT_DEFAULT = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [4:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        rebootLock,
  output logic        rebootReq
);
  core_ctl_t        ctl;
  logic [CNT_W-1:0] cnt;
  logic             expiry;

  wdt_regs #(.INIT_DEFAULT(INIT_DEFAULT)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rebootLock(rebootLock), .cnt(cnt), .expiry(expiry),
    .ctl(ctl), .rebootReq(rebootReq)
  );

  wdt_core #(.TICK_DIV(TICK_DIV), .INIT_DEFAULT(INIT_DEFAULT)) u_core (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cnt(cnt), .expiry(expiry)
  );
endmodule

// File: tb/two_stage_wdt_bench.sv
module two_stage_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int INIT0 = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rebootLock = 1'b0;
  logic        rebootReq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int lastWr = 0;
  int hEdge = 0;
  bit rdPending = 1'b0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic [4:0]  adrQ[$];

  two_stage_wdt #(.TICK_DIV(TDIV), .INIT_DEFAULT(INIT0)) u_two_stage_wdt (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rebootLock(rebootLock), .rebootReq(rebootReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN && rebootReq) pulses <= pulses + 1;
  end

  // monitor: pops the expected read result and compares it
  always @(negedge clk) begin
    if (rdPending) begin
      logic [15:0] e;
      string t;
      logic [4:0] a;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = adrQ.pop_front();
      checks++;
      if (rdData !== e) begin
        errors++;
        $display("FAIL %s: addr 0x%02h read 0x%04h expected 0x%04h", t, a, rdData, e);
      end
      rdPending = 1'b0;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
    lastWr = cyc;
  endtask

  // driver: queue the expected value, let the monitor sample it
  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
    addr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    adrQ.push_back(a);
    rdPending = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic chk(input int act, input int exp, input string t);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    rd(5'h00, 16'(INIT0), "R1 count");
    rd(5'h12, 16'(INIT0), "R1 init");
    rd(5'h08, 16'h0800, "R1 halt");
    rd(5'h04, 16'h0000, "R1 sts1");
    rd(5'h06, 16'h0000, "R1 sts2");
    repeat (30) @(posedge clk); #1;
    rd(5'h00, 16'(INIT0), "R6 halted count");
    // R2 / R3 initial value
    wr(5'h12, 16'hFC06);
    rd(5'h12, 16'h0006, "R2 upper bits");
    wr(5'h12, 16'h0003);
    rd(5'h12, 16'h0006, "R3 value 3");
    wr(5'h12, 16'h0000);
    rd(5'h12, 16'h0006, "R3 value 0");
    rd(5'h00, 16'(INIT0), "R4 no reload by init write");
    wr(5'h00, 16'h0002);
    rd(5'h00, 16'(INIT0), "R4 wrong code");
    wr(5'h00, 16'h0001);
    rd(5'h00, 16'h0006, "R4 R5 reload");
    // run: ticks at hEdge+4k, expiries at hEdge+28, +56, ...
    wr(5'h08, 16'h0000);
    hEdge = lastWr;
    rd(5'h08, 16'h0000, "R6 readback");
    waitTo(hEdge + 8);
    rd(5'h00, 16'h0004, "R7 two ticks");
    waitTo(hEdge + 24);
    rd(5'h00, 16'h0000, "R7 zero");
    waitTo(hEdge + 28);
    rd(5'h04, 16'h0008, "R8 first expiry");
    rd(5'h00, 16'h0006, "R7 reloaded");
    rd(5'h06, 16'h0000, "R8 no second");
    wr(5'h04, 16'h0008);
    rd(5'h04, 16'h0000, "R10 clear first");
    waitTo(hEdge + 56);
    rd(5'h04, 16'h0008, "R10 first again");
    rd(5'h06, 16'h0000, "R10 no second");
    chk(pulses, 0, "R10 no reboot");
    waitTo(hEdge + 84);
    rd(5'h06, 16'h0006, "R9 second expiry");
    waitTo(hEdge + 86);
    chk(pulses, 1, "R9 reboot pulse");
    waitTo(hEdge + 90);
    chk(pulses, 1, "R12 single pulse");
    wr(5'h04, 16'h0000);
    rd(5'h04, 16'h0008, "R10 write zero");
    wr(5'h06, 16'h0006);
    rd(5'h06, 16'h0000, "R10 clear sts2");
    rebootLock = 1'b1;
    waitTo(hEdge + 112);
    rd(5'h06, 16'h0002, "R11 locked second");
    waitTo(hEdge + 116);
    chk(pulses, 1, "R11 no pulse");
    // halt freezes after reload
    wr(5'h08, 16'h0800);
    wr(5'h00, 16'h0001);
    rd(5'h00, 16'h0006, "R6 reload while halted");
    rd(5'h08, 16'h0800, "R6 halt readback");
    repeat (30) @(posedge clk); #1;
    rd(5'h00, 16'h0006, "R6 frozen");
    @(posedge clk); #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule